// File: doc/BRIEF.md
# Transposable Bitwise Compute Memory

A square bit-cell array, 64 by 64 by default, that can be written and read one whole row or one whole column at a time. Data loaded along one axis and read along the other comes back transposed, with no extra storage. The same array evaluates bitwise OR and AND across a selected set of rows or columns. It returns the true result and its complement in the same pass, so NOR and NAND cost nothing extra. The result may be written into a target row or column on the same clock edge that the operation completes.

Each cell has a shadow non-volatile bit. A store command copies the whole volatile array into the shadow. A restore command copies the shadow back. A power-fail input clears the volatile array and leaves the shadow untouched, so a later restore returns the contents that were stored.

Each accepted command completes in one cycle and raises a one-cycle done strobe. Operand sets are given as a bit mask. An illegal mask raises an error flag together with done.

Top module: `xpose_cim_mem`

## Requirements
- R1: While rst_ni is low and after it rises, done_o, err_o and rdata_o are 0, and every volatile cell reads 0.
- R2: Command codes on cmd_op_i: 0 idle, 1 write, 2 read, 3 OR, 4 AND, 5 store, 6 restore. A command is accepted when cmd_valid_i is high and pwr_fail_i is low at a rising edge, and done_o is high for exactly the following cycle.
- R3: With cmd_dir_i = 0 (row), a write puts wdata_i[c] into cell (addr_i, c), and a read returns bit c of row addr_i on rdata_o[c].
- R4: With cmd_dir_i = 1 (column), a write puts wdata_i[r] into cell (r, addr_i), and a read returns cell (r, addr_i) on rdata_o[r]. A row write followed by a column read therefore yields the transpose.
- R5: OR with dir 0 uses mask_i bit r to select row r and gives rdata_o[c] = 1 when any selected row holds 1 in column c. With dir 1, mask_i selects columns and rdata_o[r] is the OR along row r. rdata_n_o always carries the complement of rdata_o (NOR/NAND).
- R6: AND with exactly two mask bits set gives 1 at a position only when both selected operands hold 1 there, in either direction.
- R7: OR with an all-zero mask, and AND with a mask that does not have exactly two bits set, complete with done_o and err_o high and change neither the array nor rdata_o.
- R8: A legal OR/AND with wb_en_i = 1 writes the result into row wb_addr_i (dir 0) or column wb_addr_i (dir 1) on the same edge. The result is computed from the cell values before that write, including when the target is one of the operands.
- R9: Store copies every volatile cell into its shadow bit. Restore copies every shadow bit back into the volatile array.
- R10: pwr_fail_i high at an edge clears every volatile cell to 0, leaves the shadow unchanged, and drops any command presented in that cycle (no done_o).
- R11: rdata_o changes only after an accepted read or a legal OR/AND. Write, store, restore, idle and error commands leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Command code |
| cmd_dir_i | input | 1 | 0 row-wise, 1 column-wise |
| addr_i | input | $clog2(DIM) | Row or column for write/read |
| mask_i | input | DIM | Operand select for OR/AND |
| wb_en_i | input | 1 | Write the logic result back |
| wb_addr_i | input | $clog2(DIM) | Write-back target row or column |
| wdata_i | input | DIM | Write data |
| pwr_fail_i | input | 1 | Supply loss: clear volatile array |
| rdata_o | output | DIM | Read or logic result |
| rdata_n_o | output | DIM | Complement of rdata_o |
| done_o | output | 1 | Command completed |
| err_o | output | 1 | Illegal operand mask |

## Verification
The bench builds the block with DIM = 16. At that size every row and column can be filled with distinct patterns and read back in both directions in a few hundred cycles. The first and last indices, single-operand and wide masks, and write-back onto an operand all fall within a short directed sequence. The full store, power-fail and restore round trip can be compared against the whole reference array.

// File: rtl/xcm_pkg.sv
package xcm_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_WRITE   = 3'd1,
    OP_READ    = 3'd2,
    OP_OR      = 3'd3,
    OP_AND     = 3'd4,
    OP_STORE   = 3'd5,
    OP_RESTORE = 3'd6
  } xcm_op_e;

  typedef struct packed {
    logic acc;
    logic wr;
    logic rd;
    logic lg_or;
    logic lg_and;
    logic store;
    logic restore;
    logic err;
  } xcm_ctl_t;
endpackage

// File: rtl/xcm_cmd_dec.sv
module xcm_cmd_dec
  import xcm_pkg::*;
#(
  parameter int unsigned DIM = 64
) (
  input  logic           valid_i,
  input  logic           pwr_fail_i,
  input  logic [2:0]     op_i,
  input  logic [DIM-1:0] mask_i,
  output xcm_ctl_t       ctl_o
);
  localparam int unsigned CW = $clog2(DIM + 1);

  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DIM; i++) cnt = cnt + CW'(mask_i[i]);
  end

  always_comb begin
    ctl_o = '0;
    if (valid_i && !pwr_fail_i) begin
      ctl_o.acc = 1'b1;
      case (xcm_op_e'(op_i))
        OP_WRITE:   ctl_o.wr = 1'b1;
        OP_READ:    ctl_o.rd = 1'b1;
        OP_OR:      if (cnt == '0) ctl_o.err = 1'b1; else ctl_o.lg_or = 1'b1;
        OP_AND:     if (cnt != CW'(2)) ctl_o.err = 1'b1; else ctl_o.lg_and = 1'b1;
        OP_STORE:   ctl_o.store = 1'b1;
        OP_RESTORE: ctl_o.restore = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/xcm_cell_array.sv
module xcm_cell_array #(
  parameter int unsigned DIM = 64,
  localparam int unsigned AW = $clog2(DIM)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    wr_en_i,
  input  logic                    wr_dir_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [DIM-1:0]          wr_data_i,
  input  logic                    store_i,
  input  logic                    restore_i,
  output logic [DIM-1:0][DIM-1:0] rows_o
);
  logic [DIM-1:0][DIM-1:0] vol_q;
  logic [DIM-1:0][DIM-1:0] shd_q;

  for (genvar r = 0; r < DIM; r++) begin : g_row
    localparam logic [AW-1:0] RI = AW'(r);
    for (genvar c = 0; c < DIM; c++) begin : g_col
      localparam logic [AW-1:0] CI = AW'(c);
      logic hit, bit_d;
      assign hit   = wr_en_i && (wr_dir_i ? (wr_addr_i == CI) : (wr_addr_i == RI));
      assign bit_d = wr_dir_i ? wr_data_i[r] : wr_data_i[c];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        vol_q[r][c] <= 1'b0;
        else if (clear_i)   vol_q[r][c] <= 1'b0;
        else if (restore_i) vol_q[r][c] <= shd_q[r][c];
        else if (hit)       vol_q[r][c] <= bit_d;
      end

      // shadow survives reset and power loss
      always_ff @(posedge clk_i) begin
        if (store_i && !clear_i) shd_q[r][c] <= vol_q[r][c];
      end
    end
  end

  assign rows_o = vol_q;
endmodule

// File: rtl/xcm_reduce.sv
module xcm_reduce #(
  parameter int unsigned DIM = 64,
  localparam int unsigned AW = $clog2(DIM)
) (
  input  logic [DIM-1:0][DIM-1:0] rows_i,
  input  logic                    dir_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DIM-1:0]          mask_i,
  output logic [DIM-1:0]          rd_o,
  output logic [DIM-1:0]          or_o,
  output logic [DIM-1:0]          and_o
);
  logic [DIM-1:0][DIM-1:0] cols;
  logic [DIM-1:0] or_rw, and_rw, or_cw, and_cw;

  for (genvar i = 0; i < DIM; i++) begin : g_lane
    for (genvar j = 0; j < DIM; j++) begin : g_tr
      assign cols[i][j] = rows_i[j][i];
    end
    // row-wise: operands are rows, one result per column
    assign or_rw[i]  = |(cols[i] & mask_i);
    assign and_rw[i] = &(cols[i] | ~mask_i);
    // column-wise: operands are columns, one result per row
    assign or_cw[i]  = |(rows_i[i] & mask_i);
    assign and_cw[i] = &(rows_i[i] | ~mask_i);
  end

  assign rd_o  = dir_i ? cols[addr_i] : rows_i[addr_i];
  assign or_o  = dir_i ? or_cw  : or_rw;
  assign and_o = dir_i ? and_cw : and_rw;
endmodule

// File: rtl/xpose_cim_mem.sv
module xpose_cim_mem
  import xcm_pkg::*;
#(
  parameter int unsigned DIM = 64,
  localparam int unsigned AW = $clog2(DIM)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_op_i,
  input  logic           cmd_dir_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DIM-1:0] mask_i,
  input  logic           wb_en_i,
  input  logic [AW-1:0]  wb_addr_i,
  input  logic [DIM-1:0] wdata_i,
  input  logic           pwr_fail_i,
  output logic [DIM-1:0] rdata_o,
  output logic [DIM-1:0] rdata_n_o,
  output logic           done_o,
  output logic           err_o
);
  xcm_ctl_t                ctl;
  logic [DIM-1:0][DIM-1:0] rows;
  logic [DIM-1:0]          rd_v, or_v, and_v, lg_v, wr_data;
  logic [AW-1:0]           wr_addr;
  logic                    wr_en, lg_ok;
  logic [DIM-1:0]          rdata_q;
  logic                    done_q, err_q;

  xcm_cmd_dec #(.DIM(DIM)) i_dec (
    .valid_i   (cmd_valid_i),
    .pwr_fail_i(pwr_fail_i),
    .op_i      (cmd_op_i),
    .mask_i    (mask_i),
    .ctl_o     (ctl)
  );

  xcm_reduce #(.DIM(DIM)) i_red (
    .rows_i(rows),
    .dir_i (cmd_dir_i),
    .addr_i(addr_i),
    .mask_i(mask_i),
    .rd_o  (rd_v),
    .or_o  (or_v),
    .and_o (and_v)
  );

  assign lg_ok   = ctl.lg_or | ctl.lg_and;
  assign lg_v    = ctl.lg_and ? and_v : or_v;
  assign wr_en   = ctl.wr | (lg_ok & wb_en_i);
  assign wr_data = ctl.wr ? wdata_i : lg_v;
  assign wr_addr = ctl.wr ? addr_i : wb_addr_i;

  xcm_cell_array #(.DIM(DIM)) i_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (pwr_fail_i),
    .wr_en_i  (wr_en),
    .wr_dir_i (cmd_dir_i),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .store_i  (ctl.store),
    .restore_i(ctl.restore),
    .rows_o   (rows)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= ctl.acc;
      err_q  <= ctl.err;
      if (ctl.rd)     rdata_q <= rd_v;
      else if (lg_ok) rdata_q <= lg_v;
    end
  end

  assign rdata_o   = rdata_q;
  assign rdata_n_o = ~rdata_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/xcm_checker.sv
module xcm_checker #(
  parameter int unsigned DIM = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_valid_i,
  input logic [2:0]     cmd_op_i,
  input logic [DIM-1:0] mask_i,
  input logic           pwr_fail_i,
  input logic [DIM-1:0] rdata_o,
  input logic           done_o,
  input logic           err_o
);
  logic acc, data_cmd;
  assign acc      = cmd_valid_i && !pwr_fail_i;
  assign data_cmd = acc && ((cmd_op_i == 3'd2) ||
                            (cmd_op_i == 3'd3 && mask_i != '0) ||
                            (cmd_op_i == 3'd4 && $countones(mask_i) == 2));

  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> done_o);
  p_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !done_o);
  p_err_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_or_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd3 && mask_i == '0) |=> err_o);
  p_and_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 3'd4 && $countones(mask_i) != 2) |=> err_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_cmd |=> $stable(rdata_o));
endmodule

bind xpose_cim_mem xcm_checker #(.DIM(DIM)) i_xcm_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_op_i   (cmd_op_i),
  .mask_i     (mask_i),
  .pwr_fail_i (pwr_fail_i),
  .rdata_o    (rdata_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/test_xpose_cim_mem.sv
`timescale 1ns/1ps
module test_xpose_cim_mem;
  localparam int DIM = 16;
  localparam int AW  = 4;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           cmd_valid_i = 1'b0;
  logic [2:0]     cmd_op_i = '0;
  logic           cmd_dir_i = 1'b0;
  logic [AW-1:0]  addr_i = '0;
  logic [DIM-1:0] mask_i = '0;
  logic           wb_en_i = 1'b0;
  logic [AW-1:0]  wb_addr_i = '0;
  logic [DIM-1:0] wdata_i = '0;
  logic           pwr_fail_i = 1'b0;
  logic [DIM-1:0] rdata_o, rdata_n_o;
  logic           done_o, err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DIM-1:0] ref_mem [DIM];
  logic [DIM-1:0] ref_shd [DIM];
  logic [DIM-1:0] exp_rdata = '0;

  always #2 clk_i = ~clk_i;

  xpose_cim_mem #(.DIM(DIM)) i_xpose_cim_mem (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DIM-1:0] act, input logic [DIM-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DIM-1:0] pat(input int s);
    return DIM'((s + 3) * 16'h9E37) ^ DIM'(16'h5A3C >> (s % 5));
  endfunction

  // one command: drive at negedge, model, compare at the following negedge
  task automatic run(input int op, input bit dir, input int addr, input logic [DIM-1:0] mask,
                     input bit wb, input int wba, input logic [DIM-1:0] wd, input bit pf,
                     input string req);
    bit exp_done, exp_err;
    logic [DIM-1:0] res;
    int n;
    exp_done = !pf;
    exp_err  = 1'b0;
    n = $countones(mask);
    if (pf) begin
      for (int r = 0; r < DIM; r++) ref_mem[r] = '0;
    end else begin
      case (op)
        1: if (!dir) ref_mem[addr] = wd;
           else for (int r = 0; r < DIM; r++) ref_mem[r][addr] = wd[r];
        2: for (int k = 0; k < DIM; k++) exp_rdata[k] = dir ? ref_mem[k][addr] : ref_mem[addr][k];
        3, 4: begin
          if ((op == 3 && n == 0) || (op == 4 && n != 2)) exp_err = 1'b1;
          else begin
            for (int k = 0; k < DIM; k++) begin
              bit acc_or = 0, acc_and = 1;
              for (int j = 0; j < DIM; j++) if (mask[j]) begin
                bit b = dir ? ref_mem[k][j] : ref_mem[j][k];
                acc_or  = acc_or | b;
                acc_and = acc_and & b;
              end
              res[k] = (op == 3) ? acc_or : acc_and;
            end
            exp_rdata = res;
            if (wb) begin
              if (!dir) ref_mem[wba] = res;
              else for (int r = 0; r < DIM; r++) ref_mem[r][wba] = res[r];
            end
          end
        end
        5: for (int r = 0; r < DIM; r++) ref_shd[r] = ref_mem[r];
        6: for (int r = 0; r < DIM; r++) ref_mem[r] = ref_shd[r];
        default: ;
      endcase
    end
    cmd_valid_i = 1'b1; cmd_op_i = 3'(op); cmd_dir_i = dir; addr_i = AW'(addr);
    mask_i = mask; wb_en_i = wb; wb_addr_i = AW'(wba); wdata_i = wd; pwr_fail_i = pf;
    @(posedge clk_i);
    @(negedge clk_i);
    cmd_valid_i = 1'b0; pwr_fail_i = 1'b0; wb_en_i = 1'b0;
    check(done_o == exp_done && err_o == exp_err, req, "done/err",
          DIM'({done_o, err_o}), DIM'({exp_done, exp_err}));
    check(rdata_o == exp_rdata && rdata_n_o == ~exp_rdata, req, "rdata", rdata_o, exp_rdata);
  endtask

  task automatic read_all(input bit dir, input string req);
    for (int a = 0; a < DIM; a++) run(2, dir, a, '0, 0, 0, '0, 0, req);
  endtask

  initial begin
    for (int r = 0; r < DIM; r++) begin ref_mem[r] = '0; ref_shd[r] = '0; end
    repeat (3) @(negedge clk_i);
    check(done_o == 0 && err_o == 0 && rdata_o == '0, "R1", "reset outputs", rdata_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(2, 0, 0, '0, 0, 0, '0, 0, "R1");
    run(2, 1, DIM-1, '0, 0, 0, '0, 0, "R1");
    run(0, 0, 0, '0, 0, 0, '0, 0, "R2");
    // R3 row fill then row read
    for (int r = 0; r < DIM; r++) run(1, 0, r, '0, 0, 0, pat(r), 0, "R3");
    read_all(0, "R3");
    // R4 transpose read, then column write
    read_all(1, "R4");
    run(1, 1, 5, '0, 0, 0, 16'hC3A5, 0, "R4");
    run(1, 1, DIM-1, '0, 0, 0, 16'h8001, 0, "R4");
    read_all(0, "R4");
    // R5 OR in both directions
    run(3, 0, 0, 16'h0212, 0, 0, '0, 0, "R5");
    run(3, 0, 0, 16'h0001, 0, 0, '0, 0, "R5");
    run(3, 1, 0, 16'h8001, 0, 0, '0, 0, "R5");
    run(3, 1, 0, 16'hFFFF, 0, 0, '0, 0, "R5");
    // R6 AND on two operands
    run(4, 0, 0, 16'h0009, 0, 0, '0, 0, "R6");
    run(4, 1, 0, 16'h8020, 0, 0, '0, 0, "R6");
    run(4, 0, 0, 16'h8001, 0, 0, '0, 0, "R6");
    // R7 illegal masks, rdata held (R11)
    run(3, 0, 0, 16'h0000, 1, 2, '0, 0, "R7");
    run(4, 0, 0, 16'h0007, 1, 2, '0, 0, "R7");
    run(4, 1, 0, 16'h0010, 1, 2, '0, 0, "R7");
    read_all(0, "R7");
    // R8 same-edge write-back, target among operands
    run(3, 0, 0, 16'h000C, 1, 2, '0, 0, "R8");
    run(4, 1, 0, 16'h0081, 1, 7, '0, 0, "R8");
    run(3, 1, 0, 16'h4002, 1, 14, '0, 0, "R8");
    run(4, 0, 0, 16'h0060, 1, 0, '0, 0, "R8");
    read_all(0, "R8");
    // R11 non-data commands keep rdata
    run(1, 0, 3, '0, 0, 0, 16'hFFFF, 0, "R11");
    // R9/R10 store, disturb, power fail, restore
    run(5, 0, 0, '0, 0, 0, '0, 0, "R9");
    run(1, 0, 4, '0, 0, 0, 16'h1234, 0, "R9");
    run(1, 0, 0, '0, 0, 0, 16'hFFFF, 1, "R10");
    read_all(1, "R10");
    run(6, 0, 0, '0, 0, 0, '0, 0, "R9");
    read_all(0, "R9");
    run(1, 1, 9, '0, 0, 0, 16'h0F0F, 0, "R9");
    run(6, 0, 0, '0, 0, 0, '0, 0, "R9");
    read_all(1, "R9");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule